// File: doc/BRIEF.md
# Two-Point DCT with Q15 Rounding

This block computes a two-point DCT of one pair of signed 16-bit samples. The sum output is y0 = (x0 + x1)/sqrt2 and the difference output is y1 = (x0 - x1)/sqrt2. Each sample is multiplied by a fixed Q15 constant equal to 1/sqrt2 times 2^15 (0x5A82, or 0xA57E when negated). The two products for each output are added into a 32-bit signed accumulator. Half an output LSB (2^14) is added to the accumulator, and the result is shifted right arithmetically by 15 bits. This gives round-to-nearest. Each result is then clamped to the signed 16-bit range.

The block accepts a new pair on every cycle in which the input valid is high. The results come out of a single register stage one cycle later, with their own valid flag. When the input valid is low, the output registers keep their contents.

Top module: `dct2_core`

## Requirements
- R1: While rst_ni is low, y0_o, y1_o and out_valid_o are all zero.
- R2: out_valid_o is high in exactly those cycles that follow a rising clock edge at which in_valid_i was high. The latency is one cycle.
- R3: y0_o = sat16(floor((x0*0x5A82 + x1*0x5A82 + 0x4000) / 2^15)). All products and sums are exact signed values.
- R4: y1_o = sat16(floor((x0*0x5A82 + x1*0xA57E + 0x4000) / 2^15)), where 0xA57E is the signed 16-bit value -0x5A82.
- R5: Rounding is to nearest. A result whose exact value lies within half an LSB below an integer rounds up to that integer. Example: x0=1, x1=0 gives y0=1 and y1=1.
- R6: The shift keeps the sign. A negative accumulator gives a negative result. Example: x0=0x00AC, x1=0x017A gives y0=0x0185 and y1=0xFF6E.
- R7: Results above 32767 are clamped to 0x7FFF, and results below -32768 are clamped to 0x8000. Example: x0=x1=0x8000 gives y0=0x8000 and y1=0.
- R8: While in_valid_i is low, changes on x0_i and x1_i have no effect: y0_o and y1_o hold their values.
- R9: Equal inputs give y1_o = 0. An input pair with x1 = 0 gives y0_o = y1_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pair valid |
| x0_i | input | 16 | First sample, signed |
| x1_i | input | 16 | Second sample, signed |
| out_valid_o | output | 1 | Output pair valid |
| y0_o | output | 16 | Sum coefficient, signed |
| y1_o | output | 16 | Difference coefficient, signed |

## Verification
The assertions check on every cycle:
- the one-cycle relation between input valid and output valid;
- that the outputs hold while no pair is accepted;
- the algebraic identities of zero input, equal inputs and a zero second input.

The exact arithmetic can only be shown by the bench scenarios. Those scenarios cover the worked example, the rounding point near half an LSB, the negative results, and the clamping at both ends of the range, all compared against independently computed values.

// File: rtl/dct2_pkg.sv
package dct2_pkg;
  parameter int DATA_W = 16;
  parameter int COEF_W = 16;
  parameter int FRAC_W = 15;
  parameter int ACC_W  = 32;
  parameter int NLANE  = 2;
  // 1/sqrt2 in Q15
  parameter logic signed [COEF_W-1:0] COEF_Q15 = 16'sh5A82;

  typedef logic signed [DATA_W-1:0] sample_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/dct2_mac.sv
module dct2_mac
  import dct2_pkg::*;
#(
  parameter bit SUB_X1 = 1'b0
) (
  input  sample_t x0_i,
  input  sample_t x1_i,
  output acc_t    acc_o
);
  localparam int EXT_D = ACC_W - DATA_W;
  localparam int EXT_C = ACC_W - COEF_W;

  acc_t x0_w, x1_w, c_w, p0, p1;

  assign x0_w = {{EXT_D{x0_i[DATA_W-1]}}, x0_i};
  assign x1_w = {{EXT_D{x1_i[DATA_W-1]}}, x1_i};
  assign c_w  = {{EXT_C{COEF_Q15[COEF_W-1]}}, COEF_Q15};
  assign p0   = x0_w * c_w;
  assign p1   = x1_w * c_w;

  generate
    if (SUB_X1) begin : g_diff
      assign acc_o = p0 - p1;
    end else begin : g_sum
      assign acc_o = p0 + p1;
    end
  endgenerate
endmodule

// File: rtl/dct2_rnd_sat.sv
module dct2_rnd_sat
  import dct2_pkg::*;
(
  input  acc_t    acc_i,
  output sample_t res_o
);
  localparam int WW = ACC_W + 1;
  localparam int HI = WW - DATA_W + 1;

  logic signed [WW-1:0] rnd_w;
  logic signed [WW-1:0] shr_w;
  logic [HI-1:0]        hi_w;
  logic                 ovf_w;

  // half-LSB add, then floor via arithmetic shift
  assign rnd_w = {acc_i[ACC_W-1], acc_i} + (WW'(1) <<< (FRAC_W - 1));
  assign shr_w = rnd_w >>> FRAC_W;
  assign hi_w  = shr_w[WW-1:DATA_W-1];
  assign ovf_w = !((&hi_w) || !(|hi_w));

  always_comb begin
    if (ovf_w) res_o = shr_w[WW-1] ? {1'b1, {(DATA_W-1){1'b0}}}
                                   : {1'b0, {(DATA_W-1){1'b1}}};
    else       res_o = shr_w[DATA_W-1:0];
  end
endmodule

// File: rtl/dct2_core.sv
module dct2_core
  import dct2_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] x0_i,
  input  logic signed [DATA_W-1:0] x1_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] y0_o,
  output logic signed [DATA_W-1:0] y1_o
);
  acc_t    acc_w [NLANE];
  sample_t res_w [NLANE];
  sample_t y_q   [NLANE];
  logic    vld_q;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    dct2_mac #(.SUB_X1(l == 1)) u_mac (
      .x0_i (x0_i),
      .x1_i (x1_i),
      .acc_o(acc_w[l])
    );
    dct2_rnd_sat u_rs (
      .acc_i(acc_w[l]),
      .res_o(res_w[l])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         y_q[l] <= '0;
      else if (in_valid_i) y_q[l] <= res_w[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= in_valid_i;
  end

  assign out_valid_o = vld_q;
  assign y0_o        = y_q[0];
  assign y1_o        = y_q[1];
endmodule

// File: rtl/dct2_chk.sv
module dct2_chk
  import dct2_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    in_valid_i,
  input sample_t x0_i,
  input sample_t x1_i,
  input logic    out_valid_o,
  input sample_t y0_o,
  input sample_t y1_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) in_valid_i |=> out_valid_o); // R2
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni) !in_valid_i |=> !out_valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !in_valid_i |=> ($stable(y0_o) && $stable(y1_o))); // R8
  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni) (in_valid_i && x0_i == 0 && x1_i == 0) |=> (y0_o == 0 && y1_o == 0)); // R3
  AST_EQ_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni) (in_valid_i && x0_i == x1_i) |=> (y1_o == 0)); // R9
  AST_X1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (in_valid_i && x1_i == 0) |=> (y0_o == y1_o)); // R9
endmodule

bind dct2_core dct2_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .x0_i       (x0_i),
  .x1_i       (x1_i),
  .out_valid_o(out_valid_o),
  .y0_o       (y0_o),
  .y1_o       (y1_o)
);

// File: tb/tb_dct2_core.sv
module tb_dct2_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] x0 = '0, x1 = '0;
  logic        ovld;
  logic [15:0] y0, y1;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dct2_core dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld),
    .x0_i(x0), .x1_i(x1),
    .out_valid_o(ovld), .y0_o(y0), .y1_o(y1)
  );

  // {x0, x1, y0, y1}
  localparam logic [63:0] VEC [10] = '{
    64'h00AC_017A_0185_FF6E, // R6 worked example
    64'h0000_0000_0000_0000, // R3
    64'h0001_0000_0001_0001, // R5
    64'h0000_0001_0001_FFFF, // R5 R6
    64'h0064_0064_008D_0000, // R3 R9
    64'h8000_8000_8000_0000, // R7 low clamp
    64'h7FFF_7FFF_7FFF_0000, // R7 high clamp
    64'h7FFF_8000_FFFF_7FFF, // R4 R7
    64'h8000_7FFF_FFFF_8000, // R4 R7
    64'hFF9C_0000_FFB9_FFB9  // R9 -100 -> -70.7
  };

  function automatic logic [15:0] ref_y(logic [15:0] a, logic [15:0] b, bit sub);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint p  = sa * 23170 + (sub ? -sb : sb) * 23170 + 16384;
    longint q  = p >>> 15;
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return q[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] hy0, hy1;
    logic [31:0] lfsr = 32'hACE1_2357;
    repeat (3) @(negedge clk);
    check("R1 y0", y0, 16'h0);
    check("R1 y1", y1, 16'h0);
    check("R1 valid", {15'b0, ovld}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      vld = 1'b1; x0 = VEC[i][63:48]; x1 = VEC[i][47:32];
      @(negedge clk);
      check("R2 valid", {15'b0, ovld}, 16'h1);
      check("R3 y0 table", y0, VEC[i][31:16]);
      check("R4 y1 table", y1, VEC[i][15:0]);
    end

    // R8: inputs change with valid low
    vld = 1'b0; hy0 = y0; hy1 = y1;
    x0 = 16'h1234; x1 = 16'hBEEF;
    @(negedge clk);
    check("R2 valid low", {15'b0, ovld}, 16'h0);
    x0 = 16'h7000;
    @(negedge clk);
    check("R8 y0 hold", y0, hy0);
    check("R8 y1 hold", y1, hy1);

    // pseudo-random stream against reference
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      vld = lfsr[7];
      x0 = lfsr[15:0]; x1 = lfsr[31:16];
      hy0 = vld ? ref_y(x0, x1, 1'b0) : y0;
      hy1 = vld ? ref_y(x0, x1, 1'b1) : y1;
      @(negedge clk);
      check("R3 y0 stream", y0, hy0);
      check("R4 y1 stream", y1, hy1);
    end

    // R1: asynchronous reset clears mid-run
    vld = 1'b1; x0 = 16'h4000; x1 = 16'h1000;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async y0", y0, 16'h0);
    check("R1 async valid", {15'b0, ovld}, 16'h0);
    finish_run();
  end
endmodule